// File: doc/BRIEF.md
# AES-128 Encryption Core with a Four-Stage Shared Round Loop

This block encrypts 128-bit blocks under a 128-bit key with the AES-128 cipher. One round's worth of logic is built once and cut into four register stages: byte substitution, row rotation, column mixing, and round-key addition. A block keeps going around this loop until all ten rounds are done. Because the loop holds four stage registers, up to four independent blocks can be in it at the same time, each one stage apart. Every block carries its own valid bit, round number and caller-supplied tag.

A key is loaded with a one-cycle strobe. The eleven round keys are then expanded, one per cycle, into a register table. The plaintext input stays blocked until that table is complete. Blocks are offered with a valid/ready pair. A block is taken only when the slot coming back to the first stage is empty or is leaving the loop in that cycle. A finished block is presented for exactly one cycle with its tag. Blocks leave in the order they were taken.

Top module: `aes128_loop_core`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are 0, and `in_ready` stays 0 until a key has been loaded and expanded.
- R2: After the clock edge that samples `key_load` high, `in_ready` is 0 for exactly 10 cycles and then returns to 1 when the loop is empty.
- R3: `out_block` is the AES-128 encryption of the accepted block under the loaded key. Byte 0 of the cipher state (row 0, column 0) is bits [127:120], byte n is bits [127-8n:120-8n], and bytes run down each column. Known case: key 000102…0f with plaintext 00112233…ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: `out_valid` is high for one cycle, 40 clock edges after the edge that accepts the block (41 cycles counting the accepting cycle).
- R5: `out_id` equals the `in_id` that was presented with the same block.
- R6: Up to four blocks are accepted on consecutive cycles. While four blocks are in the loop and none is on its last round, `in_ready` is 0.
- R7: With the loop full, the next block is accepted on the same edge at which the oldest block leaves, which is 40 edges after that oldest block was accepted.
- R8: Blocks come out in the order in which they were accepted.
- R9: A new key load replaces the whole round-key table, and later blocks are encrypted under the new key.
- R10: A block offered while `in_ready` is 0 is not taken. Every `out_valid` pulse matches exactly one accepted block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | One-cycle strobe that latches `key_in` and starts round-key expansion |
| key_in | input | 128 | Cipher key |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Block will be accepted at the next edge if `in_valid` is high |
| in_block | input | 128 | Plaintext block |
| in_id | input | ID_W | Tag that travels with the block |
| out_valid | output | 1 | Ciphertext present (one cycle per block) |
| out_block | output | 128 | Ciphertext block |
| out_id | output | ID_W | Tag of the ciphertext block |

## Verification
The known-answer block checks the byte order and the skipped column mixing in the last round. A bench reference model computed from scratch then checks every output.

A back-to-back burst of five blocks tells a correct four-slot interleave apart from a loop that takes too many blocks or stalls too long: the first four must be taken on consecutive edges and the fifth exactly when the oldest leaves.

A sweep of 64 blocks covers every tag value with patterned plaintexts, checking data, tag, ordering and the 40-edge latency. A second key load followed by 16 more blocks shows that the round-key table is rebuilt and the ready gap repeats.

// File: rtl/aes_pkg.sv
package aes_pkg;

    function automatic logic [7:0] xt(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ p;
            p = xt(p);
        end
        return acc;
    endfunction

    // substitution: multiplicative inverse by x^254, then affine map
    function automatic logic [7:0] sbox_f(input logic [7:0] x);
        logic [7:0] r;
        logic [7:0] p;
        logic [7:0] e;
        r = 8'h01;
        p = x;
        e = 8'd254;
        for (int k = 0; k < 8; k++) begin
            if (e[k]) r = gmul(r, p);
            p = gmul(p, p);
        end
        return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
                 ^ {r[3:0], r[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [7:0] get_b(input logic [127:0] s, input int n);
        return s[127-8*n -: 8];
    endfunction

    // row r of column c moves to column (c - r) mod 4
    function automatic logic [127:0] rot_rows(input logic [127:0] s);
        logic [127:0] o;
        o = '0;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[127-8*(r+4*c) -: 8] = get_b(s, r + 4*((c + r) % 4));
        return o;
    endfunction

    function automatic logic [127:0] mix_cols(input logic [127:0] s);
        logic [127:0] o;
        logic [7:0] a0, a1, a2, a3;
        o = '0;
        for (int c = 0; c < 4; c++) begin
            a0 = get_b(s, 4*c);
            a1 = get_b(s, 4*c+1);
            a2 = get_b(s, 4*c+2);
            a3 = get_b(s, 4*c+3);
            o[127-32*c      -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
            o[127-32*c-8    -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
            o[127-32*c-16   -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
            o[127-32*c-24   -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
        return o;
    endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
    input  logic [7:0] a,
    output logic [7:0] y
);
    assign y = aes_pkg::sbox_f(a);
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched #(
    parameter int ROUNDS = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [127:0]                key,
    output logic [(ROUNDS+1)*128-1:0]   rk_flat,
    output logic                        rdy
);
    localparam int CW = $clog2(ROUNDS + 1);

    typedef struct packed {
        logic [ROUNDS:0][127:0] tbl;
        logic [127:0]           last;
        logic [CW-1:0]          cnt;
        logic [7:0]             rcon;
        logic                   busy;
        logic                   rdy;
    } ks_t;

    ks_t q, d;

    logic [31:0]  rot_w;
    logic [31:0]  sub_w;
    logic [127:0] nxt;

    assign rot_w = {q.last[23:0], q.last[31:24]};

    for (genvar g = 0; g < 4; g++) begin : g_ks_sbox
        aes_sbox u_sb (.a(rot_w[8*g +: 8]), .y(sub_w[8*g +: 8]));
    end

    always_comb begin
        logic [31:0] t;
        t = sub_w ^ {q.rcon, 24'h0};
        nxt[127:96] = q.last[127:96] ^ t;
        nxt[95:64]  = q.last[95:64]  ^ nxt[127:96];
        nxt[63:32]  = q.last[63:32]  ^ nxt[95:64];
        nxt[31:0]   = q.last[31:0]   ^ nxt[63:32];
    end

    always_comb begin
        d = q;
        if (load) begin
            d.tbl[0] = key;
            d.last   = key;
            d.cnt    = CW'(1);
            d.rcon   = 8'h01;
            d.busy   = 1'b1;
            d.rdy    = 1'b0;
        end else if (q.busy) begin
            d.tbl[q.cnt] = nxt;
            d.last       = nxt;
            d.rcon       = aes_pkg::xt(q.rcon);
            d.cnt        = q.cnt + 1'b1;
            if (q.cnt == CW'(ROUNDS)) begin
                d.busy = 1'b0;
                d.rdy  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rk_flat = q.tbl;
    assign rdy     = q.rdy;

    // R9
    key_table_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rdy && !load) |=> $stable(q.tbl));

    // R2
    load_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !q.rdy);

endmodule

// File: rtl/aes_round_ring.sv
module aes_round_ring #(
    parameter int ID_W   = 4,
    parameter int ROUNDS = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       key_rdy,
    input  logic [(ROUNDS+1)*128-1:0]  rk_flat,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [127:0]               in_block,
    input  logic [ID_W-1:0]            in_id,
    output logic                       out_valid,
    output logic [127:0]               out_block,
    output logic [ID_W-1:0]            out_id
);
    localparam int RW = $clog2(ROUNDS + 1);

    typedef struct packed {
        logic            vld;
        logic [RW-1:0]   rnd;
        logic [ID_W-1:0] id;
        logic [127:0]    st;
    } slot_t;

    typedef struct packed {
        slot_t           sb;
        slot_t           sr;
        slot_t           mc;
        slot_t           ark;
        logic            ov;
        logic [127:0]    od;
        logic [ID_W-1:0] oid;
    } ring_t;

    ring_t q, d;

    logic         ark_last;
    logic         recirc;
    logic         take;
    logic [127:0] src_st;
    logic [127:0] sub_st;
    logic [127:0] rk_cur;

    assign ark_last = q.ark.vld && (q.ark.rnd == RW'(ROUNDS));
    assign recirc   = q.ark.vld && !ark_last;
    assign in_ready = key_rdy && !recirc;
    assign take     = in_valid && in_ready;
    assign src_st   = recirc ? q.ark.st : (in_block ^ rk_flat[127:0]);
    assign rk_cur   = rk_flat[int'(q.mc.rnd)*128 +: 128];

    for (genvar g = 0; g < 16; g++) begin : g_sub
        aes_sbox u_sb (.a(src_st[8*g +: 8]), .y(sub_st[8*g +: 8]));
    end

    always_comb begin
        d = q;
        // stage 1: substitution, with the entry / recirculation merge
        d.sb.st = sub_st;
        if (recirc) begin
            d.sb.vld = 1'b1;
            d.sb.rnd = q.ark.rnd + 1'b1;
            d.sb.id  = q.ark.id;
        end else begin
            d.sb.vld = take;
            d.sb.rnd = RW'(1);
            d.sb.id  = in_id;
        end
        // stage 2: row rotation
        d.sr    = q.sb;
        d.sr.st = aes_pkg::rot_rows(q.sb.st);
        // stage 3: column mixing, skipped on the final round
        d.mc    = q.sr;
        if (q.sr.rnd != RW'(ROUNDS))
            d.mc.st = aes_pkg::mix_cols(q.sr.st);
        // stage 4: round-key addition
        d.ark    = q.mc;
        d.ark.st = q.mc.st ^ rk_cur;
        // exit register
        d.ov = ark_last;
        if (ark_last) begin
            d.od  = q.ark.st;
            d.oid = q.ark.id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.ov;
    assign out_block = q.od;
    assign out_id    = q.oid;

    // R5
    entry_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (q.sb.vld && q.sb.rnd == RW'(1) && q.sb.id == $past(in_id)));

    // R7
    round_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ark.vld && q.ark.rnd != RW'(ROUNDS)) |=>
        (q.sb.vld && q.sb.rnd == $past(q.ark.rnd) + 1'b1 && q.sb.id == $past(q.ark.id)));

    // R6
    round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sb.vld |-> (q.sb.rnd >= RW'(1) && q.sb.rnd <= RW'(ROUNDS)));

    // R4
    exit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(q.ark.vld) && $past(q.ark.rnd) == RW'(ROUNDS)));

    // R1
    no_entry_without_keys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_rdy |=> !(q.sb.vld && q.sb.rnd == RW'(1) && !$past(q.ark.vld)));

endmodule

// File: rtl/aes128_loop_core.sv
module aes128_loop_core #(
    parameter int ID_W   = 4,
    parameter int ROUNDS = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            key_load,
    input  logic [127:0]    key_in,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [127:0]    in_block,
    input  logic [ID_W-1:0] in_id,
    output logic            out_valid,
    output logic [127:0]    out_block,
    output logic [ID_W-1:0] out_id
);
    logic [(ROUNDS+1)*128-1:0] rk_flat;
    logic                      key_rdy;

    aes_key_sched #(.ROUNDS(ROUNDS)) u_ks (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (key_load),
        .key     (key_in),
        .rk_flat (rk_flat),
        .rdy     (key_rdy)
    );

    aes_round_ring #(.ID_W(ID_W), .ROUNDS(ROUNDS)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_rdy   (key_rdy),
        .rk_flat   (rk_flat),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_block  (in_block),
        .in_id     (in_id),
        .out_valid (out_valid),
        .out_block (out_block),
        .out_id    (out_id)
    );
endmodule

// File: tb/aes128_loop_core_bench.sv
`timescale 1ns/1ps
module aes128_loop_core_bench;
    localparam int ID_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            key_load = 1'b0;
    logic [127:0]    key_in = '0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [127:0]    in_block = '0;
    logic [ID_W-1:0] in_id = '0;
    logic            out_valid;
    logic [127:0]    out_block;
    logic [ID_W-1:0] out_id;

    always #2.5 clk = ~clk;

    aes128_loop_core #(.ID_W(ID_W)) u_aes128_loop_core (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .in_valid(in_valid), .in_ready(in_ready), .in_block(in_block), .in_id(in_id),
        .out_valid(out_valid), .out_block(out_block), .out_id(out_id)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n_out  = 0;
    int n_acc  = 0;
    bit done   = 1'b0;
    logic [127:0] last_out;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] ref_sb [256];

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
        return p[7:0];
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv, s;
            inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (m_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i);
            ref_sb[x] = s;
        end
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] pt);
        logic [31:0] w [44];
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [7:0]  rc;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] v;
            v = w[i-1];
            if (i % 4 == 0) begin
                v = {ref_sb[v[23:16]], ref_sb[v[15:8]], ref_sb[v[7:0]], ref_sb[v[31:24]]} ^ {rc, 24'h0};
                rc = m_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ v;
        end
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) s[i] = ref_sb[s[i]];
            for (int i = 0; i < 16; i++) t[i] = s[(i%4) + 4*(((i/4) + (i%4)) % 4)];
            for (int c = 0; c < 4; c++)
                for (int rr = 0; rr < 4; rr++)
                    if (r != 10)
                        s[4*c+rr] = m_mul(8'h02, t[4*c+rr]) ^ m_mul(8'h03, t[4*c+(rr+1)%4])
                                  ^ t[4*c+(rr+2)%4] ^ t[4*c+(rr+3)%4];
                    else
                        s[4*c+rr] = t[4*c+rr];
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*r + i/4][31-8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) ref_enc[127-8*i -: 8] = s[i];
    endfunction

    // ---------------- scoreboard ----------------
    logic [127:0]    cur_key;
    logic [127:0]    exp_d [$];
    logic [ID_W-1:0] exp_i [$];
    int              exp_c [$];

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_out++;
            last_out = out_block;
            if (exp_d.size() == 0) begin
                chk(1'b0, "R10 unexpected output", out_block, '0);
            end else begin
                logic [127:0]    ed;
                logic [ID_W-1:0] ei;
                int              ec;
                ed = exp_d.pop_front();
                ei = exp_i.pop_front();
                ec = exp_c.pop_front();
                chk(out_block == ed, "R3/R8 ciphertext", out_block, ed);
                chk(out_id == ei, "R5 tag", 128'(out_id), 128'(ei));
                chk(cyc - ec == 40, "R4 latency", 128'(cyc - ec), 128'd40);
            end
        end
    end

    logic [127:0]    pt_a [128];
    logic [ID_W-1:0] id_a [128];
    int              acc_a [128];

    task automatic stream(input int first, input int n);
        int idx;
        idx = first;
        while (idx < first + n) begin
            in_valid = 1'b1;
            in_block = pt_a[idx];
            in_id    = id_a[idx];
            #1;
            if (in_ready) begin
                exp_d.push_back(ref_enc(cur_key, pt_a[idx]));
                exp_i.push_back(id_a[idx]);
                exp_c.push_back(cyc + 1);
                acc_a[idx] = cyc + 1;
                n_acc++;
                idx++;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic load_key(input logic [127:0] k, input string tag);
        int n;
        key_in   = k;
        key_load = 1'b1;
        cur_key  = k;
        @(negedge clk);
        key_load = 1'b0;
        n = 0;
        while (!in_ready && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(n == 10, tag, 128'(n), 128'd10);
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (exp_d.size() != 0 && t < 200) begin
            t++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R4 actual=hang expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        build_sbox();
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(out_valid == 1'b0, "R1 out_valid in reset", 128'(out_valid), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R10: block offered with no key is not taken
        in_valid = 1'b1;
        in_block = 128'h1;
        for (int i = 0; i < 5; i++) begin
            chk(in_ready == 1'b0, "R1 ready before key", 128'(in_ready), 128'd0);
            chk(out_valid == 1'b0, "R10 no output before key", 128'(out_valid), 128'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;

        // R2: ready gap after key load
        load_key(128'h000102030405060708090a0b0c0d0e0f, "R2 ready gap first key");

        // R3: known-answer block
        pt_a[0] = 128'h00112233445566778899aabbccddeeff;
        id_a[0] = 4'h9;
        stream(0, 1);
        drain();
        chk(last_out == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 known answer",
            last_out, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        // R6/R7: burst of five back to back
        for (int i = 0; i < 5; i++) begin
            pt_a[i] = {4{32'h1234_5678 * (i + 3)}};
            id_a[i] = ID_W'(i + 1);
        end
        stream(0, 5);
        for (int i = 1; i < 4; i++)
            chk(acc_a[i] == acc_a[0] + i, "R6 consecutive accept", 128'(acc_a[i] - acc_a[0]), 128'(i));
        chk(acc_a[4] == acc_a[0] + 40, "R7 fifth entry on oldest exit",
            128'(acc_a[4] - acc_a[0]), 128'd40);
        drain();

        // R5/R8: sweep of tags and patterned plaintexts
        for (int i = 0; i < 64; i++) begin
            pt_a[i] = {8'(i), 8'(i * 7), 8'(255 - i), 8'(i ^ 8'h5a), {3{32'h9e37_79b9 * (i + 1)}}};
            id_a[i] = ID_W'(i * 5);
        end
        stream(0, 64);
        drain();

        // R9: reload a different key and run again
        load_key(128'h2b7e151628aed2a6abf7158809cf4f3c, "R9 ready gap second key");
        for (int i = 0; i < 16; i++) begin
            pt_a[i] = {16{8'(i * 17)}};
            id_a[i] = ID_W'(15 - i);
        end
        stream(0, 16);
        drain();

        // R10: outputs match accepted blocks one for one
        chk(n_out == n_acc, "R10 output count", 128'(n_out), 128'(n_acc));
        chk(exp_d.size() == 0, "R8 queue drained", 128'(exp_d.size()), 128'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule